// File: doc/BRIEF.md
# Refresh-Flag Watchdog with Halt Freeze

This block is a watchdog clocked straight from the oscillator. It divides time into windows of fixed length. Software proves that it is alive by setting a refresh flag at some point inside each window. When a window closes, hardware reads the flag and then clears it. If software never set the flag during that window, the block emits a one-cycle watchdog reset pulse. The window count then starts again from zero.

The watchdog is off after a system reset. Software turns it on by pulsing the arm input, and only another system reset can turn it off again. A halt request that carries the halt low-power code stops the window counter. The counter stays stopped until an external wake interrupt arrives. Counting then resumes only after a fixed restart delay. The other low-power codes are active-halt, wait and slow, and they do not affect counting. The block carries no data stream, so every pin is a plain level or strobe with no handshake.

Top module: `refresh_watchdog`

## Requirements
- R1: After reset, `wdg_rst_o` and `refresh_flag_o` are low and the watchdog is disarmed, so no reset pulse appears however many cycles pass.
- R2: A cycle with `arm_i` high arms the watchdog. Driving `arm_i` low afterwards does not disarm it. Only `rst_n` disarms it.
- R3: Counting starts on the first clock edge after the arming edge. If the arming edge is edge A and no refresh occurs, reset pulses are seen after edges A+WIN_CLKS, A+2*WIN_CLKS and so on.
- R4: `wdg_rst_o` is high for exactly one cycle, and the next window is a full WIN_CLKS long.
- R5: A cycle with `refresh_set_i` high while running sets `refresh_flag_o` from the next cycle on. A window that closes with the flag set issues no pulse and leaves the flag clear.
- R6: If `refresh_set_i` is high in the cycle that closes a window, no pulse is issued and `refresh_flag_o` is low afterwards.
- R7: A cycle with `halt_req_i` high and `lp_mode_i` = 2'b00 (halt) freezes the watchdog from the next edge on. The window count and the flag keep their values, `refresh_set_i` is ignored, and no pulse is issued.
- R8: When `halt_req_i` is high with `lp_mode_i` = 2'b01 (active-halt), 2'b10 (wait) or 2'b11 (slow), nothing changes.
- R9: If `wake_irq_i` is high on edge W during a halt, the window count resumes at edge W+WAKE_DELAY+1. The frozen span from halt edge H adds W+WAKE_DELAY-H cycles to pulse times. `wake_irq_i` has no effect outside halt.
- R10: Asserting `rst_n` while the watchdog is armed returns it to the disarmed, flag-clear, running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| arm_i | input | 1 | Arms the watchdog (sticky until reset) |
| refresh_set_i | input | 1 | Software strobe that sets the refresh flag |
| halt_req_i | input | 1 | Request to enter the low-power mode given by lp_mode_i |
| wake_irq_i | input | 1 | External interrupt that ends a halt |
| lp_mode_i | input | 2 | Low-power code: 00 halt, 01 active-halt, 10 wait, 11 slow |
| wdg_rst_o | output | 1 | One-cycle watchdog reset pulse |
| refresh_flag_o | output | 1 | Current refresh flag |

## Verification
The hardest timings to reach from the ports are two edge cases. One is a refresh strobe that lands in exactly the cycle that closes a window. The other is a pulse time shifted by a halt and by the restart delay that follows the wake. The bench drives every input on falling edges and keeps a cycle index. From the recorded arm, halt and wake edges it computes each expected pulse edge and queues it. The stimulus places the strobe at edge A+WIN_CLKS and holds a halt across what would have been a window end. It also sets the flag before a halt to show that the flag survives the freeze and the restart delay.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_HALT = 2'd1,
    PWR_WAKE = 2'd2
  } pwr_state_e;

  localparam logic [1:0] LP_HALT        = 2'b00;
  localparam logic [1:0] LP_ACTIVE_HALT = 2'b01;
  localparam logic [1:0] LP_WAIT        = 2'b10;
  localparam logic [1:0] LP_SLOW        = 2'b11;
endpackage

// File: rtl/wdg_power_ctl.sv
module wdg_power_ctl
  import wdg_pkg::*;
#(
  parameter int WAKE_DELAY = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic [1:0] lp_mode,
  input  logic       wake_irq,
  output pwr_state_e state,
  output logic       running
);
  localparam int DLY_W = (WAKE_DELAY > 1) ? $clog2(WAKE_DELAY) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(WAKE_DELAY - 1);

  pwr_state_e           state_q;
  logic [DLY_W-1:0]     dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_RUN;
      dly_q   <= '0;
    end else begin
      case (state_q)
        PWR_RUN: begin
          if (halt_req && lp_mode == LP_HALT) state_q <= PWR_HALT;
        end
        PWR_HALT: begin
          if (wake_irq) begin
            state_q <= PWR_WAKE;
            dly_q   <= '0;
          end
        end
        PWR_WAKE: begin
          if (dly_q == DLY_LAST) begin
            state_q <= PWR_RUN;
            dly_q   <= '0;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        default: state_q <= PWR_RUN;
      endcase
    end
  end

  assign state   = state_q;
  assign running = (state_q == PWR_RUN);
endmodule

// File: rtl/wdg_window_ctr.sv
module wdg_window_ctr #(
  parameter int WIN_CLKS = 16000,
  parameter int CNT_W    = $clog2(WIN_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             running,
  output logic             win_end,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIN_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign win_end = armed && running && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (armed && running) begin
      if (win_end) cnt_q <= '0;
      else         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdg_refresh_flag.sv
module wdg_refresh_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic win_end,
  input  logic set_strobe,
  output logic flag,
  output logic rst_pulse
);
  logic flag_q;
  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= win_end && !flag_q && !set_strobe;
      if (win_end)                    flag_q <= 1'b0;
      else if (running && set_strobe) flag_q <= 1'b1;
    end
  end

  assign flag      = flag_q;
  assign rst_pulse = pulse_q;
endmodule

// File: rtl/refresh_watchdog.sv
module refresh_watchdog
  import wdg_pkg::*;
#(
  parameter int WIN_CLKS   = 16000,
  parameter int WAKE_DELAY = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic       refresh_set_i,
  input  logic       halt_req_i,
  input  logic       wake_irq_i,
  input  logic [1:0] lp_mode_i,
  output logic       wdg_rst_o,
  output logic       refresh_flag_o
);
  localparam int CNT_W = $clog2(WIN_CLKS);

  logic             armed_q;
  logic             running;
  logic             win_end;
  logic [CNT_W-1:0] win_count;
  pwr_state_e       pwr_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (arm_i) armed_q <= 1'b1;
  end

  wdg_power_ctl #(.WAKE_DELAY(WAKE_DELAY)) u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_req (halt_req_i),
    .lp_mode  (lp_mode_i),
    .wake_irq (wake_irq_i),
    .state    (pwr_state),
    .running  (running)
  );

  wdg_window_ctr #(.WIN_CLKS(WIN_CLKS), .CNT_W(CNT_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (armed_q),
    .running (running),
    .win_end (win_end),
    .count   (win_count)
  );

  wdg_refresh_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .win_end    (win_end),
    .set_strobe (refresh_set_i),
    .flag       (refresh_flag_o),
    .rst_pulse  (wdg_rst_o)
  );
endmodule

// File: rtl/refresh_watchdog_chk.sv
module refresh_watchdog_chk
  import wdg_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input logic             running,
  input logic             win_end,
  input logic             set_strobe,
  input logic             halt_req,
  input logic             wake_irq,
  input logic [1:0]       lp_mode,
  input logic             pulse,
  input logic             flag,
  input logic [CNT_W-1:0] count,
  input pwr_state_e       state
);
  a_r1_pulse_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> armed);
  a_r2_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  a_r4_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (count == '0));
  a_r5_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> !flag);
  a_r6_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && set_strobe) |=> (!pulse && !flag));
  a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(count));
  a_r7_flag_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(flag));
  a_r8_other_modes: assert property (@(posedge clk) disable iff (!rst_n)
    (running && halt_req && lp_mode != LP_HALT) |=> running);
  a_r9_stay_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_HALT && !wake_irq) |=> (state == PWR_HALT));
endmodule

bind refresh_watchdog refresh_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .armed      (armed_q),
  .running    (running),
  .win_end    (win_end),
  .set_strobe (refresh_set_i),
  .halt_req   (halt_req_i),
  .wake_irq   (wake_irq_i),
  .lp_mode    (lp_mode_i),
  .pulse      (wdg_rst_o),
  .flag       (refresh_flag_o),
  .count      (win_count),
  .state      (pwr_state)
);

// File: tb/tb_refresh_watchdog.sv
module tb_refresh_watchdog;
  localparam int W = 100;
  localparam int D = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm_i = 1'b0;
  logic       refresh_set_i = 1'b0;
  logic       halt_req_i = 1'b0;
  logic       wake_irq_i = 1'b0;
  logic [1:0] lp_mode_i = 2'b00;
  logic       wdg_rst_o;
  logic       refresh_flag_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  refresh_watchdog #(.WIN_CLKS(W), .WAKE_DELAY(D)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .arm_i          (arm_i),
    .refresh_set_i  (refresh_set_i),
    .halt_req_i     (halt_req_i),
    .wake_irq_i     (wake_irq_i),
    .lp_mode_i      (lp_mode_i),
    .wdg_rst_o      (wdg_rst_o),
    .refresh_flag_o (refresh_flag_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: compare observed reset pulses with the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (wdg_rst_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R4 unexpected pulse", cyc, -1);
        end else begin
          check(exp_q[0] == cyc, "R3 pulse edge", cyc, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end else if (exp_q.size() != 0 && exp_q[0] == cyc) begin
        check(1'b0, "R3 missing pulse", 0, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Driver: arm the watchdog and return the arming edge index.
  task automatic arm(output int a);
    @(negedge clk);
    arm_i = 1'b1;
    a = cyc + 1;
    @(negedge clk);
    arm_i = 1'b0;
  endtask

  task automatic strobe_set();
    refresh_set_i = 1'b1;
    @(negedge clk);
    refresh_set_i = 1'b0;
  endtask

  task automatic queue_done(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    int a;
    int h;
    int w;
    int sh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, no pulses while disarmed
    check(wdg_rst_o == 1'b0, "R1 pulse after reset", wdg_rst_o, 0);
    check(refresh_flag_o == 1'b0, "R1 flag after reset", refresh_flag_o, 0);
    repeat (3 * W) @(negedge clk);
    queue_done("R1 disarmed quiet");

    // R2/R3/R4: arm, no refresh, periodic pulses
    arm(a);
    exp_q.push_back(a + W);
    exp_q.push_back(a + 2 * W);
    wait_until(a + W + 1);
    check(wdg_rst_o == 1'b0, "R4 pulse width", wdg_rst_o, 0);
    wait_until(a + 2 * W + 5);
    queue_done("R2 stays armed, R3 period");

    // R10: reset while armed disarms
    wait_until(cyc + W - 10);
    do_reset();
    repeat (3 * W) @(negedge clk);
    check(refresh_flag_o == 1'b0, "R10 flag after reset", refresh_flag_o, 0);
    queue_done("R10 disarmed after reset");

    // R5: refresh in first window only
    arm(a);
    wait_until(a + 40);
    strobe_set();
    check(refresh_flag_o == 1'b1, "R5 flag set", refresh_flag_o, 1);
    wait_until(a + W);
    check(refresh_flag_o == 1'b0, "R5 flag cleared at window end", refresh_flag_o, 0);
    exp_q.push_back(a + 2 * W);
    wait_until(a + 2 * W + 5);
    queue_done("R5 refreshed window quiet");

    // R6: strobe coincident with window end
    do_reset();
    arm(a);
    exp_q.push_back(a + 2 * W);
    wait_until(a + W - 1);
    strobe_set();
    check(refresh_flag_o == 1'b0, "R6 flag after coincident strobe", refresh_flag_o, 0);
    wait_until(a + 2 * W + 5);
    queue_done("R6 no pulse on coincident strobe");

    // R8 and R9 (wake outside halt): other modes leave timing unchanged
    do_reset();
    arm(a);
    exp_q.push_back(a + W);
    wait_until(a + 20); lp_mode_i = 2'b01; halt_req_i = 1'b1; @(negedge clk); halt_req_i = 1'b0;
    wait_until(a + 30); lp_mode_i = 2'b10; halt_req_i = 1'b1; @(negedge clk); halt_req_i = 1'b0;
    wait_until(a + 40); lp_mode_i = 2'b11; halt_req_i = 1'b1; @(negedge clk); halt_req_i = 1'b0;
    wait_until(a + 50); wake_irq_i = 1'b1; @(negedge clk); wake_irq_i = 1'b0;
    lp_mode_i = 2'b00;
    wait_until(a + W + 5);
    queue_done("R8 non-halt modes, R9 stray wake");

    // R7/R9: halt shifts the pulse, strobes ignored while frozen
    do_reset();
    arm(a);
    wait_until(a + 30);
    halt_req_i = 1'b1; h = cyc + 1; @(negedge clk); halt_req_i = 1'b0;
    repeat (40) @(negedge clk);
    strobe_set();
    check(refresh_flag_o == 1'b0, "R7 strobe ignored in halt", refresh_flag_o, 0);
    repeat (100) @(negedge clk);
    wake_irq_i = 1'b1; w = cyc + 1; @(negedge clk); wake_irq_i = 1'b0;
    sh = w + D - h;
    exp_q.push_back(a + W + sh);
    wait_until(a + W + sh + 5);
    queue_done("R9 pulse shifted by halt and delay");

    // R7: flag kept across halt and restart delay
    do_reset();
    arm(a);
    wait_until(a + 10);
    strobe_set();
    wait_until(a + 20);
    halt_req_i = 1'b1; h = cyc + 1; @(negedge clk); halt_req_i = 1'b0;
    repeat (150) @(negedge clk);
    check(refresh_flag_o == 1'b1, "R7 flag held in halt", refresh_flag_o, 1);
    wake_irq_i = 1'b1; w = cyc + 1; @(negedge clk); wake_irq_i = 1'b0;
    repeat (D / 2) @(negedge clk);
    check(refresh_flag_o == 1'b1, "R7 flag held in restart delay", refresh_flag_o, 1);
    sh = w + D - h;
    exp_q.push_back(a + 2 * W + sh);
    wait_until(a + W + sh);
    check(refresh_flag_o == 1'b0, "R5 flag cleared after halt", refresh_flag_o, 0);
    wait_until(a + 2 * W + sh + 5);
    queue_done("R7 retained flag suppressed pulse");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule